// File: doc/BRIEF.md
# Display Mode-Change Power Sequencer

This block steps a display path through a safe mode change. The path has four parts: a scan-out plane, a timing pipe, a pixel clock synthesizer and an analog output port. One pulse on `start` makes the sequencer take the path down in a fixed order. It then waits for the pipe to report idle, and it opens a key-guarded window to reprogram the synthesizer. After that it closes the window and brings the path back up in the reverse order. Each step drives either a level enable or a one-cycle load strobe toward the register file of the path.

The clock-enable request is captured when the sequence is accepted. With the request clear, the synthesizer is written stopped and the path stays down. With the request set, the synthesizer is written twice, first stopped and then running, and a fixed settling wait follows each write. The output port is then enabled with its power state held off. Timings, pipe and surface are loaded before the port is powered on. A readback check on the synthesizer run bit triggers a single corrective rewrite when needed. If the pipe never reports idle, the sequence still runs to the end and flags a timeout.

Top module: `modeset_seq`

## Requirements
- R1: After reset every enable, strobe, the guard word, `done` and `timeoutErr` are 0.
- R2: `start` is accepted only when the sequencer is idle. A `start` during a sequence has no effect on any output. An accepted `start` clears `timeoutErr` and captures `pllEnReq` for the whole sequence.
- R3: Shutdown order: `planeEn` falls one cycle after `start` is taken. `pipeEn` falls in the next cycle together with a `pipeOffWr` pulse. After the idle poll, `portEn` and `dpmsOn` go to 0 and `vgaDis` goes to 1 and stays 1.
- R4: The pipe is polled once per cycle. Each poll that sees `pipeBusy` high issues another `pipeOffWr` pulse. The first poll that sees it low moves on in the next cycle.
- R5: If POLLS polls in a row all see `pipeBusy` high, `timeoutErr` rises after the last one and the sequence continues. `timeoutErr` then holds until the next accepted `start`. If the last allowed poll sees the pipe idle, no timeout is raised.
- R6: `protKey` carries UNLOCK_KEY (default 0xABCD0000) from the unlock step until the relock step, and is 0 at all other times. Every bit of `fpWr` pulses in the same single cycle, which falls inside that window.
- R7: The synthesizer control is written with `pllVco`=0 first. It is written again with `pllVco`=1 only when the captured request is 1.
- R8: After each synthesizer control write, SETTLE_CYC cycles pass with no output change before the next step.
- R9: With the captured request 0, `done` pulses in the cycle after relock, and `portEn`, `pipeEn` and `planeEn` stay 0.
- R10: With the captured request 1, the bring-up runs one step per cycle after relock: `portEn` rises with `dpmsOn` still 0, then `timingLd`, then `pipeEn`, then `surfLd`, then `dpmsOn`.
- R11: One cycle after `dpmsOn` rises, `pllVcoRb` is sampled. If it is low, a single rewrite with `pllVco`=1 is made, followed by a settling wait. `planeEn` then rises. If it is high, `planeEn` rises in the next cycle.
- R12: `done` is a one-cycle pulse in the cycle after the last enable step, and the sequencer is idle in the cycle after that.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| start | input | 1 | Request a mode change (taken only when idle) |
| pipeBusy | input | 1 | Pipe still active |
| pllEnReq | input | 1 | Run the clock synthesizer after reprogramming |
| pllVcoRb | input | 1 | Readback of the synthesizer run bit |
| planeEn | output | 1 | Scan-out plane enable |
| pipeEn | output | 1 | Timing pipe enable |
| pipeOffWr | output | 1 | Strobe: write pipe disable |
| portEn | output | 1 | Analog port enable |
| dpmsOn | output | 1 | Analog port power state on |
| vgaDis | output | 1 | Legacy compatibility path disabled |
| protKey | output | KEY_W | Word driven to the synthesizer guard register |
| fpWr | output | FP_REGS | Strobes: load each feedback divider register |
| pllCtlWr | output | 1 | Strobe: load synthesizer control |
| pllVco | output | 1 | Run bit value for the control write |
| timingLd | output | 1 | Strobe: load timing registers |
| surfLd | output | 1 | Strobe: load surface registers |
| done | output | 1 | Sequence complete pulse |
| timeoutErr | output | 1 | Pipe idle poll ran out |

## Verification
Two cases can fall in the same cycle: the last allowed idle poll and the pipe reporting idle. The bench holds `pipeBusy` high for exactly POLLS-1 polls, so the final poll sees the pipe idle and must leave `timeoutErr` low. A second run holds it high for POLLS polls, and the final poll must both re-issue the disable and raise the timeout while the sequence carries on. In another run, `start` is raised again while the shutdown is in progress, and the cycle-accurate reference must show no disturbance to any output.

// File: rtl/modeset_pkg.sv
package modeset_pkg;

  typedef enum logic [4:0] {
    ST_IDLE,
    ST_PLANE_OFF,
    ST_PIPE_OFF,
    ST_POLL,
    ST_PORT_OFF,
    ST_UNLOCK,
    ST_FP_WR,
    ST_PLL_OFF,
    ST_SETTLE_A,
    ST_PLL_ON,
    ST_SETTLE_B,
    ST_LOCK,
    ST_PORT_ON,
    ST_TIMING,
    ST_PIPE_ON,
    ST_SURF,
    ST_DPMS,
    ST_VERIFY,
    ST_REWRITE,
    ST_SETTLE_C,
    ST_PLANE_ON,
    ST_DONE
  } seqState_t;

  typedef struct packed {
    logic planeOff;
    logic planeOn;
    logic pipeOff;
    logic pipeOn;
    logic portOff;
    logic portOn;
    logic dpmsUp;
    logic keyOpen;
    logic keyClose;
    logic fpLoad;
    logic pllWr;
    logic vcoVal;
    logic timLoad;
    logic surfLoad;
    logic seqDone;
    logic setErr;
    logic clrErr;
    logic cntInc;
    logic latchReq;
  } seqCmd_t;

endpackage

// File: rtl/modeset_ctrl.sv
module modeset_ctrl
  import modeset_pkg::*;
(
  input  logic    clk,
  input  logic    rstN,
  input  logic    start,
  input  logic    pipeBusy,
  input  logic    pllVcoRb,
  input  logic    reqLat,
  input  logic    pollLast,
  input  logic    settleLast,
  output seqCmd_t cmd
);

  seqState_t st, nx;

  always_ff @(posedge clk) begin
    if (!rstN) st <= ST_IDLE;
    else       st <= nx;
  end

  always_comb begin
    cmd = '0;
    nx  = st;
    unique case (st)
      ST_IDLE: begin
        if (start) begin
          cmd.clrErr   = 1'b1;
          cmd.latchReq = 1'b1;
          nx = ST_PLANE_OFF;
        end
      end
      ST_PLANE_OFF: begin
        cmd.planeOff = 1'b1;
        nx = ST_PIPE_OFF;
      end
      ST_PIPE_OFF: begin
        cmd.pipeOff = 1'b1;
        nx = ST_POLL;
      end
      ST_POLL: begin
        if (pipeBusy) begin
          cmd.pipeOff = 1'b1;
          cmd.cntInc  = 1'b1;
          if (pollLast) begin
            cmd.setErr = 1'b1;
            nx = ST_PORT_OFF;
          end
        end else begin
          nx = ST_PORT_OFF;
        end
      end
      ST_PORT_OFF: begin
        cmd.portOff = 1'b1;
        nx = ST_UNLOCK;
      end
      ST_UNLOCK: begin
        cmd.keyOpen = 1'b1;
        nx = ST_FP_WR;
      end
      ST_FP_WR: begin
        cmd.fpLoad = 1'b1;
        nx = ST_PLL_OFF;
      end
      ST_PLL_OFF: begin
        cmd.pllWr  = 1'b1;
        cmd.vcoVal = 1'b0;
        nx = ST_SETTLE_A;
      end
      ST_SETTLE_A: begin
        cmd.cntInc = 1'b1;
        if (settleLast) nx = reqLat ? ST_PLL_ON : ST_LOCK;
      end
      ST_PLL_ON: begin
        cmd.pllWr  = 1'b1;
        cmd.vcoVal = 1'b1;
        nx = ST_SETTLE_B;
      end
      ST_SETTLE_B: begin
        cmd.cntInc = 1'b1;
        if (settleLast) nx = ST_LOCK;
      end
      ST_LOCK: begin
        cmd.keyClose = 1'b1;
        nx = reqLat ? ST_PORT_ON : ST_DONE;
      end
      ST_PORT_ON: begin
        cmd.portOn = 1'b1;
        nx = ST_TIMING;
      end
      ST_TIMING: begin
        cmd.timLoad = 1'b1;
        nx = ST_PIPE_ON;
      end
      ST_PIPE_ON: begin
        cmd.pipeOn = 1'b1;
        nx = ST_SURF;
      end
      ST_SURF: begin
        cmd.surfLoad = 1'b1;
        nx = ST_DPMS;
      end
      ST_DPMS: begin
        cmd.dpmsUp = 1'b1;
        nx = ST_VERIFY;
      end
      ST_VERIFY: begin
        nx = pllVcoRb ? ST_PLANE_ON : ST_REWRITE;
      end
      ST_REWRITE: begin
        cmd.pllWr  = 1'b1;
        cmd.vcoVal = 1'b1;
        nx = ST_SETTLE_C;
      end
      ST_SETTLE_C: begin
        cmd.cntInc = 1'b1;
        if (settleLast) nx = ST_PLANE_ON;
      end
      ST_PLANE_ON: begin
        cmd.planeOn = 1'b1;
        nx = ST_DONE;
      end
      ST_DONE: begin
        cmd.seqDone = 1'b1;
        nx = ST_IDLE;
      end
      default: nx = ST_IDLE;
    endcase
  end

endmodule

// File: rtl/modeset_dp.sv
module modeset_dp
  import modeset_pkg::*;
#(
  parameter int                 POLLS      = 100,
  parameter int                 SETTLE_CYC = 4,
  parameter int                 KEY_W      = 32,
  parameter int                 FP_REGS    = 2,
  parameter logic [KEY_W-1:0]   UNLOCK_KEY = 32'hABCD_0000
) (
  input  logic               clk,
  input  logic               rstN,
  input  seqCmd_t            cmd,
  input  logic               pllEnReq,
  output logic               reqLat,
  output logic               pollLast,
  output logic               settleLast,
  output logic               planeEn,
  output logic               pipeEn,
  output logic               pipeOffWr,
  output logic               portEn,
  output logic               dpmsOn,
  output logic               vgaDis,
  output logic [KEY_W-1:0]   protKey,
  output logic [FP_REGS-1:0] fpWr,
  output logic               pllCtlWr,
  output logic               pllVco,
  output logic               timingLd,
  output logic               surfLd,
  output logic               done,
  output logic               timeoutErr
);

  localparam int CNT_MAX = (POLLS > SETTLE_CYC) ? POLLS : SETTLE_CYC;
  localparam int CNT_W   = $clog2(CNT_MAX + 1);

  logic [CNT_W-1:0] cnt;

  assign pollLast   = (cnt == CNT_W'(POLLS - 1));
  assign settleLast = (cnt == CNT_W'(SETTLE_CYC - 1));

  always_ff @(posedge clk) begin
    if (!rstN) cnt <= '0;
    else if (cmd.cntInc) cnt <= cnt + 1'b1;
    else cnt <= '0;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      planeEn    <= 1'b0;
      pipeEn     <= 1'b0;
      portEn     <= 1'b0;
      dpmsOn     <= 1'b0;
      vgaDis     <= 1'b0;
      protKey    <= '0;
      pllVco     <= 1'b0;
      timeoutErr <= 1'b0;
      reqLat     <= 1'b0;
    end else begin
      if (cmd.latchReq) reqLat <= pllEnReq;
      if (cmd.planeOff) planeEn <= 1'b0;
      else if (cmd.planeOn) planeEn <= 1'b1;
      if (cmd.pipeOff) pipeEn <= 1'b0;
      else if (cmd.pipeOn) pipeEn <= 1'b1;
      if (cmd.portOff) begin
        portEn <= 1'b0;
        dpmsOn <= 1'b0;
        vgaDis <= 1'b1;
      end else if (cmd.portOn) begin
        portEn <= 1'b1;
      end
      if (cmd.dpmsUp) dpmsOn <= 1'b1;
      if (cmd.keyOpen) protKey <= UNLOCK_KEY;
      else if (cmd.keyClose) protKey <= '0;
      if (cmd.pllWr) pllVco <= cmd.vcoVal;
      if (cmd.clrErr) timeoutErr <= 1'b0;
      else if (cmd.setErr) timeoutErr <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      pipeOffWr <= 1'b0;
      pllCtlWr  <= 1'b0;
      timingLd  <= 1'b0;
      surfLd    <= 1'b0;
      done      <= 1'b0;
    end else begin
      pipeOffWr <= cmd.pipeOff;
      pllCtlWr  <= cmd.pllWr;
      timingLd  <= cmd.timLoad;
      surfLd    <= cmd.surfLoad;
      done      <= cmd.seqDone;
    end
  end

  for (genvar g = 0; g < FP_REGS; g++) begin : gFpStrobe
    always_ff @(posedge clk) begin
      if (!rstN) fpWr[g] <= 1'b0;
      else       fpWr[g] <= cmd.fpLoad;
    end
  end

endmodule

// File: rtl/modeset_seq.sv
module modeset_seq
  import modeset_pkg::*;
#(
  parameter int                 POLLS      = 100,
  parameter int                 SETTLE_CYC = 4,
  parameter int                 KEY_W      = 32,
  parameter int                 FP_REGS    = 2,
  parameter logic [KEY_W-1:0]   UNLOCK_KEY = 32'hABCD_0000
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               start,
  input  logic               pipeBusy,
  input  logic               pllEnReq,
  input  logic               pllVcoRb,
  output logic               planeEn,
  output logic               pipeEn,
  output logic               pipeOffWr,
  output logic               portEn,
  output logic               dpmsOn,
  output logic               vgaDis,
  output logic [KEY_W-1:0]   protKey,
  output logic [FP_REGS-1:0] fpWr,
  output logic               pllCtlWr,
  output logic               pllVco,
  output logic               timingLd,
  output logic               surfLd,
  output logic               done,
  output logic               timeoutErr
);

  seqCmd_t cmd;
  logic    reqLat;
  logic    pollLast;
  logic    settleLast;

  modeset_ctrl ctrl_i (
    .clk        (clk),
    .rstN       (rstN),
    .start      (start),
    .pipeBusy   (pipeBusy),
    .pllVcoRb   (pllVcoRb),
    .reqLat     (reqLat),
    .pollLast   (pollLast),
    .settleLast (settleLast),
    .cmd        (cmd)
  );

  modeset_dp #(
    .POLLS      (POLLS),
    .SETTLE_CYC (SETTLE_CYC),
    .KEY_W      (KEY_W),
    .FP_REGS    (FP_REGS),
    .UNLOCK_KEY (UNLOCK_KEY)
  ) dp_i (
    .clk        (clk),
    .rstN       (rstN),
    .cmd        (cmd),
    .pllEnReq   (pllEnReq),
    .reqLat     (reqLat),
    .pollLast   (pollLast),
    .settleLast (settleLast),
    .planeEn    (planeEn),
    .pipeEn     (pipeEn),
    .pipeOffWr  (pipeOffWr),
    .portEn     (portEn),
    .dpmsOn     (dpmsOn),
    .vgaDis     (vgaDis),
    .protKey    (protKey),
    .fpWr       (fpWr),
    .pllCtlWr   (pllCtlWr),
    .pllVco     (pllVco),
    .timingLd   (timingLd),
    .surfLd     (surfLd),
    .done       (done),
    .timeoutErr (timeoutErr)
  );

endmodule

// File: rtl/modeset_seq_chk.sv
module modeset_seq_chk #(
  parameter int               KEY_W      = 32,
  parameter int               FP_REGS    = 2,
  parameter logic [KEY_W-1:0] UNLOCK_KEY = 32'hABCD_0000
) (
  input logic               clk,
  input logic               rstN,
  input logic               planeEn,
  input logic               pipeEn,
  input logic               pipeOffWr,
  input logic               portEn,
  input logic               dpmsOn,
  input logic [KEY_W-1:0]   protKey,
  input logic [FP_REGS-1:0] fpWr,
  input logic               pllVco,
  input logic               done
);

  assert_plane_before_pipe_R3: assert property (@(posedge clk) disable iff (!rstN)
    $fell(pipeEn) |-> !planeEn);

  assert_reissue_pipe_down_R4: assert property (@(posedge clk) disable iff (!rstN)
    pipeOffWr |-> (!pipeEn && !planeEn));

  assert_divider_in_window_R6: assert property (@(posedge clk) disable iff (!rstN)
    (|fpWr) |-> (protKey == UNLOCK_KEY));

  assert_port_needs_clock_R10: assert property (@(posedge clk) disable iff (!rstN)
    $rose(portEn) |-> (pllVco && !dpmsOn));

  assert_pipe_after_port_R10: assert property (@(posedge clk) disable iff (!rstN)
    $rose(pipeEn) |-> (portEn && pllVco));

  assert_power_on_last_R10: assert property (@(posedge clk) disable iff (!rstN)
    $rose(dpmsOn) |-> (portEn && pipeEn));

  assert_plane_after_power_R11: assert property (@(posedge clk) disable iff (!rstN)
    $rose(planeEn) |-> (pipeEn && dpmsOn));

  assert_done_single_R12: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);

endmodule

bind modeset_seq modeset_seq_chk #(
  .KEY_W      (KEY_W),
  .FP_REGS    (FP_REGS),
  .UNLOCK_KEY (UNLOCK_KEY)
) chk_i (
  .clk       (clk),
  .rstN      (rstN),
  .planeEn   (planeEn),
  .pipeEn    (pipeEn),
  .pipeOffWr (pipeOffWr),
  .portEn    (portEn),
  .dpmsOn    (dpmsOn),
  .protKey   (protKey),
  .fpWr      (fpWr),
  .pllVco    (pllVco),
  .done      (done)
);

// File: tb/modeset_seq_tb_top.sv
`timescale 1ns/1ps
module modeset_seq_tb_top;

  localparam int          POLLS  = 100;
  localparam int          SETTLE = 4;
  localparam logic [31:0] KEY    = 32'hABCD_0000;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic start = 1'b0, pipeBusy = 1'b0, pllEnReq = 1'b0, pllVcoRb = 1'b1;
  logic planeEn, pipeEn, pipeOffWr, portEn, dpmsOn, vgaDis;
  logic [31:0] protKey;
  logic [1:0]  fpWr;
  logic pllCtlWr, pllVco, timingLd, surfLd, done, timeoutErr;

  always #2 clk = ~clk;

  modeset_seq #(.POLLS(POLLS), .SETTLE_CYC(SETTLE)) dut_i (
    .clk(clk), .rstN(rstN), .start(start), .pipeBusy(pipeBusy),
    .pllEnReq(pllEnReq), .pllVcoRb(pllVcoRb), .planeEn(planeEn),
    .pipeEn(pipeEn), .pipeOffWr(pipeOffWr), .portEn(portEn),
    .dpmsOn(dpmsOn), .vgaDis(vgaDis), .protKey(protKey), .fpWr(fpWr),
    .pllCtlWr(pllCtlWr), .pllVco(pllVco), .timingLd(timingLd),
    .surfLd(surfLd), .done(done), .timeoutErr(timeoutErr)
  );

  int errors = 0;
  int checks = 0;
  bit finished = 1'b0;
  string curReq = "R1";

  logic ePlane = 0, ePipe = 0, ePipeOff = 0, ePort = 0, eDpms = 0, eVga = 0;
  logic [31:0] eKey = '0;
  logic [1:0]  eFp = '0;
  logic ePllWr = 0, eVco = 0, eTim = 0, eSurf = 0, eDone = 0, eErr = 0;

  task automatic compare();
    logic [14:0] act, exp;
    act = {planeEn, pipeEn, pipeOffWr, portEn, dpmsOn, vgaDis, fpWr,
           pllCtlWr, pllVco, timingLd, surfLd, done, timeoutErr, 1'b0};
    exp = {ePlane, ePipe, ePipeOff, ePort, eDpms, eVga, eFp,
           ePllWr, eVco, eTim, eSurf, eDone, eErr, 1'b0};
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s t=%0t outputs got %h expected %h", curReq, $time, act, exp);
    end
    checks++;
    if (protKey !== eKey) begin
      errors++;
      $display("FAIL %s t=%0t protKey got %h expected %h", curReq, $time, protKey, eKey);
    end
  endtask

  task automatic cycle();
    @(posedge clk);
    @(negedge clk);
    compare();
    ePipeOff = 0; eFp = '0; ePllWr = 0; eTim = 0; eSurf = 0; eDone = 0;
  endtask

  task automatic settle();
    curReq = "R8";
    for (int i = 0; i < SETTLE; i++) cycle();
  endtask

  task automatic runSeq(input int nBusy, input bit req, input bit rbOk, input bit injectStart);
    int polls;
    bit stop;
    curReq = "R2";
    start = 1; pllEnReq = req; pllVcoRb = rbOk;
    eErr = 0;
    cycle();
    start = 0; pllEnReq = ~req;
    curReq = "R3";
    ePlane = 0;
    cycle();
    if (injectStart) begin start = 1; curReq = "R2"; end
    ePipe = 0; ePipeOff = 1;
    cycle();
    start = 0;
    polls = 0;
    stop = 0;
    while (!stop) begin
      curReq = "R4";
      pipeBusy = (polls < nBusy);
      if (pipeBusy) begin
        ePipeOff = 1;
        if (polls == POLLS - 1) begin
          curReq = "R5"; eErr = 1; stop = 1;
        end
      end else begin
        stop = 1;
      end
      cycle();
      polls++;
    end
    pipeBusy = 0;
    curReq = "R3";
    ePort = 0; eDpms = 0; eVga = 1;
    cycle();
    curReq = "R6";
    eKey = KEY;
    cycle();
    eFp = 2'b11;
    cycle();
    curReq = "R7";
    ePllWr = 1; eVco = 0;
    cycle();
    settle();
    if (req) begin
      curReq = "R7";
      ePllWr = 1; eVco = 1;
      cycle();
      settle();
    end
    curReq = "R6";
    eKey = '0;
    cycle();
    if (req) begin
      curReq = "R10";
      ePort = 1; cycle();
      eTim = 1;  cycle();
      ePipe = 1; cycle();
      eSurf = 1; cycle();
      eDpms = 1; cycle();
      curReq = "R11";
      cycle();
      if (!rbOk) begin
        ePllWr = 1; eVco = 1;
        cycle();
        settle();
      end
      curReq = "R11";
      ePlane = 1;
      cycle();
    end else begin
      curReq = "R9";
    end
    curReq = "R12";
    eDone = 1;
    cycle();
    cycle();
    cycle();
  endtask

  initial begin
    #(4 * 200000);
    if (!finished) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1;
    curReq = "R1";
    cycle();
    cycle();
    runSeq(0, 1'b1, 1'b1, 1'b0);
    runSeq(5, 1'b1, 1'b0, 1'b1);
    runSeq(POLLS - 1, 1'b0, 1'b1, 1'b0);
    runSeq(POLLS, 1'b1, 1'b1, 1'b0);
    runSeq(2, 1'b1, 1'b1, 1'b0);
    runSeq(1, 1'b0, 1'b0, 1'b1);
    finished = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule